// File: doc/BRIEF.md
# Audio Low-Pass, Decimate-by-Eight and Resonant Filter Pipeline

This block filters a 48 kHz stream of 16-bit two's complement audio samples. The stream first passes through a second-order anti-alias low-pass section. A decimator then keeps one low-pass result in every eight, which gives an 8 kHz stream. A second-order resonant (bandpass) section can run on either stream. Running it at 8 kHz lets a narrow low-frequency resonance keep good accuracy with short coefficients.

Both sections use direct form I. Their coefficients are signed fixed-point parameters with 2 integer bits and 16 fraction bits. Each output rate has its own valid strobe. Two select inputs control the resonant section. One turns it on. The other chooses whether it is fed from the full-rate stream or from the decimated stream.

Top module: `audioDecimFilter`

## Requirements
- R1: While `rstN` is low, `fullValid`, `decValid`, `fullSample` and `decSample` are 0. The decimation phase returns to count 0.
- R2: `fullValid` rises exactly one clock after each `inValid` cycle. If `filtEn` is 0 or `useDecim` is 1, `fullSample` at that point equals the input sample of that cycle.
- R3: `decValid` pulses exactly two clocks after the 1st, 9th, 17th, ... `inValid` cycle counted from reset. It is never high in two consecutive cycles.
- R4: The low-pass section computes `acc = b0*x[n] + b1*x[n-1] + b2*x[n-2] - a1*y[n-1] - a2*y[n-2]` at full width. The coefficients are Q2.16 integers. The result is `(acc + 32768) >>> 16`. When `filtEn` is 0, `decSample` is the low-pass output of the kept sample.
- R5: A section whose rounded result is above 32767 outputs 32767. A rounded result below -32768 gives -32768. The output never wraps.
- R6: With `filtEn`=1 and `useDecim`=0, `fullSample` is the resonant section's output for that cycle's input sample. The resonant arithmetic follows R4.
- R7: With `filtEn`=1 and `useDecim`=1, the resonant section steps once per kept low-pass sample, and `decSample` is its output.
- R8: A section's history advances only on a cycle where it takes a sample. Gaps in `inValid` do not change the result. The resonant history is frozen while `filtEn` is 0.
- R9: `fullSample` and `decSample` hold their last value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe (48 kHz rate) |
| inSample | input | 16 | Input sample, two's complement |
| filtEn | input | 1 | 1 enables the resonant section |
| useDecim | input | 1 | 1 feeds the resonant section from the 8 kHz stream |
| fullValid | output | 1 | Full-rate output strobe |
| fullSample | output | 16 | Full-rate output sample |
| decValid | output | 1 | Decimated output strobe |
| decSample | output | 16 | Decimated output sample |

## Verification
The latency and clamping assertions assume that `filtEn` and `useDecim` change only while `rstN` is low. They also assume that the coefficient parameters describe stable sections. The bench therefore sets the mode bits before each reset release and holds them for the whole segment. It uses only stable Q2.16 coefficient sets. The stimulus includes gaps in `inValid`, a square wave near the resonant frequency, and full-scale steps. The full-scale steps push the low-pass overshoot into saturation. A `filtEn` toggle inside a full-rate segment exercises the frozen resonant history.

// File: rtl/audioFiltPkg.sv
package audioFiltPkg;
  localparam int DATA_W = 16;
  localparam int COEF_W = 18;
  localparam int FRAC_W = 16;
  localparam int ACC_W  = DATA_W + COEF_W + 3;

  typedef logic signed [DATA_W-1:0] sample_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  typedef struct packed {
    logic signed [COEF_W-1:0] b0;
    logic signed [COEF_W-1:0] b1;
    logic signed [COEF_W-1:0] b2;
    logic signed [COEF_W-1:0] a1;
    logic signed [COEF_W-1:0] a2;
  } coefSet_t;

  typedef struct packed {
    logic lpLoad;
    logic bpLoad;
    logic bpSelDec;
    logic keep;
    logic fullLoad;
    logic fullUseBp;
    logic decUseBp;
  } strobes_t;
endpackage

// File: rtl/biquadSection.sv
module biquadSection
  import audioFiltPkg::*;
#(
  parameter coefSet_t COEF = '0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    load,
  input  sample_t x,
  output sample_t yNext
);
  localparam acc_t SAT_HI = acc_t'((2 ** (DATA_W - 1)) - 1);
  localparam acc_t SAT_LO = acc_t'(-(2 ** (DATA_W - 1)));
  localparam acc_t ROUND  = acc_t'(2 ** (FRAC_W - 1));

  sample_t x1, x2, y1, y2;
  acc_t    acc, rnd;

  always_comb begin
    acc = acc_t'($signed(COEF.b0)) * acc_t'(x)
        + acc_t'($signed(COEF.b1)) * acc_t'(x1)
        + acc_t'($signed(COEF.b2)) * acc_t'(x2)
        - acc_t'($signed(COEF.a1)) * acc_t'(y1)
        - acc_t'($signed(COEF.a2)) * acc_t'(y2);
    rnd = (acc + ROUND) >>> FRAC_W;
    if (rnd > SAT_HI)      yNext = sample_t'(SAT_HI);
    else if (rnd < SAT_LO) yNext = sample_t'(SAT_LO);
    else                   yNext = sample_t'(rnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      x1 <= '0; x2 <= '0; y1 <= '0; y2 <= '0;
    end else if (load) begin
      x2 <= x1; x1 <= x;
      y2 <= y1; y1 <= yNext;
    end
  end

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (load && rnd > SAT_HI) |=> (y1 == sample_t'(SAT_HI))); // R5
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (load && rnd < SAT_LO) |=> (y1 == sample_t'(SAT_LO))); // R5
  AST_STATE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> ($stable(y1) && $stable(x1))); // R8
endmodule

// File: rtl/filterCtrl.sv
module filterCtrl
  import audioFiltPkg::*;
#(
  parameter int DECIM = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     filtEn,
  input  logic     useDecim,
  output strobes_t stb,
  output logic     fullValid,
  output logic     decValid
);
  localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic [CNT_W-1:0] phase;
  logic             lpValidQ;
  logic             keep;

  assign keep = lpValidQ && (phase == '0);

  always_comb begin
    stb.lpLoad    = inValid;
    stb.fullLoad  = inValid;
    stb.keep      = keep;
    stb.bpSelDec  = useDecim;
    stb.bpLoad    = filtEn && (useDecim ? keep : inValid);
    stb.fullUseBp = filtEn && !useDecim;
    stb.decUseBp  = filtEn && useDecim;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= '0;
      lpValidQ  <= 1'b0;
      fullValid <= 1'b0;
      decValid  <= 1'b0;
    end else begin
      lpValidQ  <= inValid;
      fullValid <= inValid;
      decValid  <= keep;
      if (lpValidQ)
        phase <= (phase == CNT_W'(DECIM - 1)) ? '0 : phase + 1'b1;
    end
  end

  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(inValid, 2)); // R3
  AST_DEC_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid); // R3
endmodule

// File: rtl/filterDatapath.sv
module filterDatapath
  import audioFiltPkg::*;
#(
  parameter coefSet_t LP_COEF = '0,
  parameter coefSet_t BP_COEF = '0
) (
  input  logic     clk,
  input  logic     rstN,
  input  strobes_t stb,
  input  sample_t  inSample,
  output sample_t  fullSample,
  output sample_t  decSample
);
  sample_t lpNext, lpHold, bpIn, bpNext;

  biquadSection #(.COEF(LP_COEF)) uLowPass (
    .clk(clk), .rstN(rstN), .load(stb.lpLoad), .x(inSample), .yNext(lpNext)
  );

  assign bpIn = stb.bpSelDec ? lpHold : inSample;

  biquadSection #(.COEF(BP_COEF)) uResonant (
    .clk(clk), .rstN(rstN), .load(stb.bpLoad), .x(bpIn), .yNext(bpNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lpHold     <= '0;
      fullSample <= '0;
      decSample  <= '0;
    end else begin
      if (stb.lpLoad)   lpHold     <= lpNext;
      if (stb.fullLoad) fullSample <= stb.fullUseBp ? bpNext : inSample;
      if (stb.keep)     decSample  <= stb.decUseBp ? bpNext : lpHold;
    end
  end

  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.keep |=> $stable(decSample)); // R9
endmodule

// File: rtl/audioDecimFilter.sv
module audioDecimFilter
  import audioFiltPkg::*;
#(
  parameter int       DECIM   = 8,
  parameter coefSet_t LP_COEF = '{b0: 18'sd2130, b1: 18'sd4260, b2: 18'sd2130,
                                  a1: -18'sd94372, a2: 18'sd37356},
  parameter coefSet_t BP_COEF = '{b0: 18'sd2523, b1: 18'sd0, b2: -18'sd2523,
                                  a1: -18'sd121242, a2: 18'sd60490}
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [15:0] inSample,
  input  logic        filtEn,
  input  logic        useDecim,
  output logic        fullValid,
  output logic [15:0] fullSample,
  output logic        decValid,
  output logic [15:0] decSample
);
  strobes_t stb;
  sample_t  fullS, decS;

  filterCtrl #(.DECIM(DECIM)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .filtEn(filtEn),
    .useDecim(useDecim), .stb(stb), .fullValid(fullValid), .decValid(decValid)
  );

  filterDatapath #(.LP_COEF(LP_COEF), .BP_COEF(BP_COEF)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .inSample(sample_t'(inSample)),
    .fullSample(fullS), .decSample(decS)
  );

  assign fullSample = fullS;
  assign decSample  = decS;

  AST_FULL_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> fullValid); // R2
  AST_FULL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !fullValid); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(fullSample)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!fullValid && !decValid)); // R1
endmodule

// File: tb/audioDecimFilter_test.sv
`timescale 1ns/1ps
module audioDecimFilter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inSample = '0;
  logic        filtEn = 1'b0;
  logic        useDecim = 1'b0;
  logic        fullValid, decValid;
  logic [15:0] fullSample, decSample;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audioDecimFilter uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .filtEn(filtEn), .useDecim(useDecim), .fullValid(fullValid),
    .fullSample(fullSample), .decValid(decValid), .decSample(decSample)
  );

  // Reference coefficients, Q2.16 integers
  int lpC[5] = '{2130, 4260, 2130, -94372, 37356};
  int bpC[5] = '{2523, 0, -2523, -121242, 60490};

  // Reference state
  int lpX1, lpX2, lpY1, lpY2, bpX1, bpX2, bpY1, bpY2;
  int mLpOut, mCnt;
  bit mLpV;
  bit expFullV, expDecV;
  int expFull, expDec;
  string fullTag, decTag;

  function automatic int stepSec(input int c[5], inout int x1, inout int x2,
                                 inout int y1, inout int y2, input int x);
    longint acc, r;
    int y;
    acc = longint'(c[0]) * x + longint'(c[1]) * x1 + longint'(c[2]) * x2
        - longint'(c[3]) * y1 - longint'(c[4]) * y2;
    r = (acc + 64'sd32768) >>> 16;
    if (r > 32767) y = 32767;
    else if (r < -32768) y = -32768;
    else y = int'(r);
    x2 = x1; x1 = x; y2 = y1; y1 = y;
    return y;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    lpX1 = 0; lpX2 = 0; lpY1 = 0; lpY2 = 0;
    bpX1 = 0; bpX2 = 0; bpY1 = 0; bpY2 = 0;
    mLpOut = 0; mCnt = 0; mLpV = 0;
    expFullV = 0; expDecV = 0; expFull = 0; expDec = 0;
  endtask

  task automatic compareAll();
    check("R2", "fullValid", int'(fullValid), int'(expFullV));
    check("R3", "decValid", int'(decValid), int'(expDecV));
    check((expFull == 32767 || expFull == -32768) ? "R5" : fullTag,
          "fullSample", int'($signed(fullSample)), expFull);
    check((expDec == 32767 || expDec == -32768) ? "R5" : decTag,
          "decSample", int'($signed(decSample)), expDec);
  endtask

  // R1: reset state, mode bits set while reset is held
  task automatic doReset(input bit en, input bit dec, input string fTag, input string dTag);
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; filtEn = en; useDecim = dec;
    modelReset();
    fullTag = fTag; decTag = dTag;
    repeat (2) @(negedge clk);
    check("R1", "fullValid", int'(fullValid), 0);
    check("R1", "decValid", int'(decValid), 0);
    check("R1", "fullSample", int'($signed(fullSample)), 0);
    check("R1", "decSample", int'($signed(decSample)), 0);
    rstN = 1'b1;
  endtask

  // One cycle: drive at negedge, update reference, compare at following negedge
  task automatic step(input bit v, input int x);
    bit keep, bpLoad, fullBp, decBp;
    int bpY;
    inValid = v;
    inSample = 16'(x);
    keep = mLpV && (mCnt == 0);
    fullBp = filtEn && !useDecim;
    decBp = filtEn && useDecim;
    bpLoad = filtEn && (useDecim ? keep : v);
    bpY = 0;
    if (bpLoad)
      bpY = stepSec(bpC, bpX1, bpX2, bpY1, bpY2, useDecim ? mLpOut : x);
    expDecV = keep;
    if (keep) expDec = decBp ? bpY : mLpOut;
    expFullV = v;
    if (v) expFull = fullBp ? bpY : x;
    if (mLpV) mCnt = (mCnt + 1) % 8;
    if (v) mLpOut = stepSec(lpC, lpX1, lpX2, lpY1, lpY2, x);
    mLpV = v;
    @(negedge clk);
    compareAll();
  endtask

  function automatic int squareAt(input int n, input int half, input int amp);
    return ((n / half) % 2 == 0) ? amp : -amp;
  endfunction

  initial begin
    int seed;
    seed = 12345;
    // R4: low-pass and decimation only, dense samples, filter off
    doReset(1'b0, 1'b1, "R2", "R4");
    for (int n = 0; n < 400; n++) begin
      seed = seed * 1103515245 + 12345;
      step(1'b1, ((seed >>> 8) % 12000));
    end
    // R6: resonant section on the full-rate stream
    doReset(1'b1, 1'b0, "R6", "R4");
    for (int n = 0; n < 700; n++) step(1'b1, squareAt(n, 40, 20000));
    // R7: resonant section on the decimated stream, square near resonance
    doReset(1'b1, 1'b1, "R2", "R7");
    for (int n = 0; n < 1600; n++) step(1'b1, squareAt(n, 64, 20000));
    // R5: full-scale steps drive the low-pass overshoot into clamping
    doReset(1'b0, 1'b1, "R2", "R5");
    for (int n = 0; n < 480; n++) step(1'b1, ((n / 48) % 2 == 0) ? 32767 : -32768);
    // R8: gaps in inValid and a resonant section switched off and on again
    doReset(1'b1, 1'b0, "R8", "R8");
    for (int n = 0; n < 500; n++) begin
      if (n == 150) filtEn = 1'b0;
      if (n == 300) filtEn = 1'b1;
      step((n % 3) != 1, squareAt(n, 25, 15000));
    end
    // R9: sparse samples, outputs hold between strobes, decimated path on
    doReset(1'b1, 1'b1, "R9", "R9");
    for (int n = 0; n < 600; n++) step((n % 5) == 0, squareAt(n, 70, 18000));
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1-watchdog actual=running expected=finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule